// File: doc/BRIEF.md
# Clock Gating Power Controller

This block decides which clock domains of a chip receive pulses. It holds one enable bit per peripheral domain and one for the processor core. It derives each gated clock from the free-running system clock through a latch-based gating cell, so a gated clock never produces a shortened pulse. Software sets peripheral enable bits through one write code and clears them through another. A change reaches the gated clock on the next clock pulse. Gating only withholds the clock edges, so every register behind a gate keeps its value and carries on from there when the clock returns.

Stopping the core is a deferred operation. A stop write raises a pending flag. The core clock keeps running until the core reports through `insn_done` that its current instruction has finished, and only then does the gate close. After that, the core clock stays off until an interrupt line arrives that is allowed by the wake mask, or until a synchronous reset. An allowed interrupt that arrives while a stop is still pending cancels the stop.

All control writes go through a single strobe with a 2-bit code and a data word: code 0 sets peripheral enables, code 1 clears them, code 2 requests a core stop, and code 3 loads the wake mask.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After a synchronous reset, every peripheral enable and the core enable read 1, `stop_pending` is 0, the wake mask is all zeros, and all gated clocks pulse.
- R2: A write with code 0 sets each peripheral enable whose `wr_data` bit is 1 and leaves the other enables unchanged. `per_status` shows the result right after the write edge.
- R3: A write with code 1 clears each peripheral enable whose `wr_data` bit is 1 and leaves the other enables unchanged. `per_status` shows the result right after the write edge.
- R4: Bit i of `per_clk` pulses in exactly those clock cycles that follow an edge at which peripheral enable i was 1. The gated output is always low while `clk` is low.
- R5: A write with code 2 while the core runs sets `stop_pending` and leaves the peripheral enables unchanged. The core clock keeps pulsing while `insn_done` is 0.
- R6: At the first edge where `stop_pending` and `insn_done` are both 1 and no allowed interrupt is present, `core_running` falls and `stop_pending` clears. From the next cycle on, `core_clk` has no pulse.
- R7: While the core is stopped and no allowed interrupt is present, the core stays stopped whatever `insn_done` does.
- R8: A write with code 3 loads the wake mask from the low `wr_data` bits. While the core is stopped, an interrupt line that is set and also set in the mask raises `core_running` at the next edge. The core clock then pulses in the cycle after that, which is within two cycles of the interrupt.
- R9: An interrupt line whose mask bit is 0 has no effect on the core clock.
- R10: An allowed interrupt present at an edge while a stop is pending clears `stop_pending`, and the core keeps running even if `insn_done` rises later.
- R11: A synchronous reset while the core is stopped and some peripherals are gated turns all clocks back on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 2 | Write code: 0 set enables, 1 clear enables, 2 core stop, 3 wake mask |
| wr_data | input | DW | Write data; DW is the larger of N_PERIPH and N_IRQ |
| insn_done | input | 1 | Core signals that the current instruction has completed |
| irq | input | N_IRQ | Interrupt request lines |
| core_clk | output | 1 | Gated core clock |
| per_clk | output | N_PERIPH | Gated peripheral clocks |
| per_status | output | N_PERIPH | Current peripheral enable bits |
| core_running | output | 1 | Core clock enable state |
| stop_pending | output | 1 | A core stop is waiting for an instruction boundary |

## Verification
The bench builds the block with N_PERIPH = 6 and N_IRQ = 3. With these values the data word is wider than the mask, and neither count is a power of two. The unused upper data bits on a mask write are therefore exercised, and every peripheral gate can be toggled one by one in a short table. The small interrupt count lets the bench hold a masked line and an allowed line at the same time. This is how it tells the masking rule apart from the wake rule.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
  typedef enum logic [1:0] {
    SEL_PER_SET  = 2'd0,
    SEL_PER_CLR  = 2'd1,
    SEL_CORE_OFF = 2'd2,
    SEL_WAKE_MSK = 2'd3
  } wr_code_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clkpm_gate_cell.sv
// Latch-based clock gate: enable is captured while clk is low, so the
// output can only rise together with clk and never gets a clipped pulse.
module clkpm_gate_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  always_latch begin
    if (!clk_i) en_lat <= en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/clkpm_periph_regs.sv
module clkpm_periph_regs
  import clkpm_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int DW       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DW-1:0]       wr_data,
  output logic [N_PERIPH-1:0] en_q
);
  logic [N_PERIPH-1:0] bits;
  logic                do_set;
  logic                do_clr;

  assign bits   = wr_data[N_PERIPH-1:0];
  assign do_set = wr_en && (wr_sel == SEL_PER_SET);
  assign do_clr = wr_en && (wr_sel == SEL_PER_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '1;
    end else if (do_set) begin
      en_q <= en_q | bits;
    end else if (do_clr) begin
      en_q <= en_q & ~bits;
    end
  end

  // R2: set write raises selected bits and keeps the others
  a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
    do_set |=> ((en_q & $past(bits)) == $past(bits)) &&
               ((en_q & ~$past(bits)) == ($past(en_q) & ~$past(bits))));
  // R3: clear write drops selected bits and keeps the others
  a_r3_clr_bits: assert property (@(posedge clk) disable iff (rst)
    do_clr |=> ((en_q & $past(bits)) == '0) &&
               ((en_q & ~$past(bits)) == ($past(en_q) & ~$past(bits))));
  // R5: without a peripheral write the enables hold
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !(do_set || do_clr) |=> $stable(en_q));
endmodule

// File: rtl/clkpm_core_ctrl.sv
module clkpm_core_ctrl
  import clkpm_pkg::*;
#(
  parameter int N_IRQ = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             insn_done,
  input  logic [N_IRQ-1:0] irq,
  output logic             core_en,
  output logic             pend
);
  logic [N_IRQ-1:0] wake_mask;
  logic             wake;
  logic             stop_req;

  assign wake     = |(irq & wake_mask);
  assign stop_req = wr_en && (wr_sel == SEL_CORE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_mask <= '0;
    end else if (wr_en && (wr_sel == SEL_WAKE_MSK)) begin
      wake_mask <= wr_data[N_IRQ-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_en <= 1'b1;
      pend    <= 1'b0;
    end else if (wake && (!core_en || pend)) begin
      core_en <= 1'b1;
      pend    <= 1'b0;
    end else if (pend && insn_done) begin
      core_en <= 1'b0;
      pend    <= 1'b0;
    end else if (stop_req && core_en) begin
      pend    <= 1'b1;
    end
  end

  // R6: gate closes at the instruction boundary
  a_r6_close_on_done: assert property (@(posedge clk) disable iff (rst)
    (pend && insn_done && !wake) |=> (!core_en && !pend));
  // R7: stopped core stays stopped without an allowed interrupt
  a_r7_stay_off: assert property (@(posedge clk) disable iff (rst)
    (!core_en && !wake) |=> !core_en);
  // R8: allowed interrupt restarts a stopped core at the next edge
  a_r8_wake: assert property (@(posedge clk) disable iff (rst)
    (!core_en && wake) |=> (core_en && !pend));
  // R10: allowed interrupt cancels a pending stop
  a_r10_cancel: assert property (@(posedge clk) disable iff (rst)
    (pend && wake) |=> (core_en && !pend));
  // R5: pending only while running, and the core stays up until done
  a_r5_pend_running: assert property (@(posedge clk) disable iff (rst)
    (pend && !insn_done) |=> core_en);
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clkpm_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int N_IRQ    = 4,
  localparam int DW      = max_of(N_PERIPH, N_IRQ)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DW-1:0]       wr_data,
  input  logic                insn_done,
  input  logic [N_IRQ-1:0]    irq,
  output logic                core_clk,
  output logic [N_PERIPH-1:0] per_clk,
  output logic [N_PERIPH-1:0] per_status,
  output logic                core_running,
  output logic                stop_pending
);
  logic [N_PERIPH-1:0] per_en;
  logic                core_en;
  logic                pend;

  clkpm_periph_regs #(.N_PERIPH(N_PERIPH), .DW(DW)) u_pregs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .en_q    (per_en)
  );

  clkpm_core_ctrl #(.N_IRQ(N_IRQ), .DW(DW)) u_core (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .insn_done (insn_done),
    .irq       (irq),
    .core_en   (core_en),
    .pend      (pend)
  );

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_per_gate
    clkpm_gate_cell u_gate (
      .clk_i  (clk),
      .en_i   (per_en[g]),
      .gclk_o (per_clk[g])
    );
  end

  clkpm_gate_cell u_core_gate (
    .clk_i  (clk),
    .en_i   (core_en),
    .gclk_o (core_clk)
  );

  assign per_status   = per_en;
  assign core_running = core_en;
  assign stop_pending = pend;
endmodule

// File: tb/clk_pwr_ctrl_test.sv
module clk_pwr_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam int NI = 3;
  localparam int DW = (NP > NI) ? NP : NI;
  localparam int NV = 8;
  // each entry: {code[1:0], data[5:0], expected status[5:0]}
  localparam logic [13:0] VEC [NV] = '{
    {2'd1, 6'b000101, 6'b111010},
    {2'd1, 6'b110000, 6'b001010},
    {2'd0, 6'b000001, 6'b001011},
    {2'd0, 6'b000000, 6'b001011},
    {2'd1, 6'b111111, 6'b000000},
    {2'd0, 6'b100100, 6'b100100},
    {2'd0, 6'b011011, 6'b111111},
    {2'd2, 6'b000011, 6'b111111}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic          insn_done = 1'b0;
  logic [NI-1:0] irq = '0;
  logic          core_clk;
  logic [NP-1:0] per_clk;
  logic [NP-1:0] per_status;
  logic          core_running;
  logic          stop_pending;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_pwr_ctrl #(.N_PERIPH(NP), .N_IRQ(NI)) uut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel),
    .wr_data (wr_data), .insn_done (insn_done), .irq (irq),
    .core_clk (core_clk), .per_clk (per_clk), .per_status (per_status),
    .core_running (core_running), .stop_pending (stop_pending)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // move to 2 time units after the next rising edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic write(input logic [1:0] code, input logic [DW-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = code; wr_data = data;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    step();
    // R1 reset state
    check("R1 status", 32'(per_status), 32'h3f);
    check("R1 running", 32'(core_running), 1);
    check("R1 pending", 32'(stop_pending), 0);
    check("R1 per_clk", 32'(per_clk), 32'h3f);
    check("R1 core_clk", 32'(core_clk), 1);

    for (int i = 0; i < NV; i++) begin
      write(VEC[i][13:12], DW'(VEC[i][11:6]));
      check("R2/R3 status", 32'(per_status), 32'(VEC[i][5:0]));
      step();
      check("R4 per_clk pulse", 32'(per_clk), 32'(VEC[i][5:0]));
      @(negedge clk); #2;
      check("R4 low phase", 32'(per_clk), 0);
    end

    // R5: last vector requested a stop; core keeps pulsing without done
    check("R5 pending", 32'(stop_pending), 1);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R5 core_clk runs", 32'(core_clk), 1);
    end

    // R6: boundary reached
    @(negedge clk) insn_done = 1'b1;
    step();
    check("R6 running", 32'(core_running), 0);
    check("R6 pending", 32'(stop_pending), 0);
    @(negedge clk) insn_done = 1'b0;
    step();
    check("R6 core_clk off", 32'(core_clk), 0);
    check("R6 per_clk still on", 32'(per_clk), 32'h3f);

    // R7/R9: masked interrupt, toggling done, core stays off
    @(negedge clk) begin irq = 3'b001; insn_done = 1'b1; end
    for (int k = 0; k < 3; k++) begin
      step();
      check("R7/R9 core_clk off", 32'(core_clk), 0);
    end
    @(negedge clk) insn_done = 1'b0;
    write(2'd3, DW'(6'b111010)); // mask = 3'b010, upper bits ignored
    check("R9 still stopped", 32'(core_running), 0);
    step();
    check("R9 core_clk off", 32'(core_clk), 0);

    // R8: allowed interrupt wakes within two cycles
    @(negedge clk) irq = 3'b011;
    step();
    check("R8 running", 32'(core_running), 1);
    step();
    check("R8 core_clk back", 32'(core_clk), 1);

    // R10: wake cancels a pending stop
    @(negedge clk) irq = '0;
    write(2'd2, '0);
    check("R10 pending set", 32'(stop_pending), 1);
    @(negedge clk) irq = 3'b010;
    step();
    check("R10 pending cleared", 32'(stop_pending), 0);
    @(negedge clk) begin irq = '0; insn_done = 1'b1; end
    step();
    step();
    check("R10 core still on", 32'(core_clk), 1);
    @(negedge clk) insn_done = 1'b0;

    // R11: reset while stopped and gated
    write(2'd1, DW'(6'b010110));
    write(2'd2, '0);
    @(negedge clk) insn_done = 1'b1;
    step();
    check("R11 stopped first", 32'(core_running), 0);
    @(negedge clk) begin rst = 1'b1; insn_done = 1'b0; end
    step();
    @(negedge clk) rst = 1'b0;
    check("R11 status", 32'(per_status), 32'h3f);
    check("R11 running", 32'(core_running), 1);
    step();
    check("R11 core_clk", 32'(core_clk), 1);
    check("R11 per_clk", 32'(per_clk), 32'h3f);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule